// File: doc/BRIEF.md
# Narrow Bus Transfer Sequencer

The sequencer takes one fragment request from a requester: an address, a length of one to three bytes, a direction and, for writes, right-aligned write data. It turns that request into the smallest possible series of cycles on a 16-bit, word-oriented I/O bus and then answers the requester once.

Reads on this bus always move a full 16-bit word. The requester selects the byte it wants from the result, which is returned in longword position. Writes use word cycles only where a word cycle touches nothing but the addressed bytes; everywhere else they use byte cycles. The sequencer never reads a location in order to rewrite it. Two things make that necessary: an I/O read can change device state, and rewriting a whole word has a different effect from writing a single byte.

Each bus cycle finishes on a done strobe, which may carry an error flag. A cycle that gets no done strobe within a fixed number of clocks is abandoned. An error or a timeout ends the request at once, and the cycles still pending are skipped.

Top module: `nbt_seq`

## Requirements
- R1: After reset, req_ready is 1, bus_valid is 0 and rsp_valid is 0.
- R2: A read whose length plus address bit 0 is at most 2 performs one word read cycle. Any other read performs two word read cycles: the first at the address with bit 0 cleared, the second at that address plus 2. Read cycles always have bus_byte=0.
- R3: The result of a one-cycle read puts the word in rsp_rdata[31:16] when address bit 1 is 1, and in rsp_rdata[15:0] with the other half zero when it is 0. For a two-cycle read, rsp_rdata is {second word, first word}.
- R4: A 1-byte write is a single byte cycle (bus_write=1, bus_byte=1) at the request address. The byte travels in bus_wdata[15:8] when address bit 0 is 1 and in bus_wdata[7:0] when it is 0, and the unused lane is zero.
- R5: A 2-byte write to an even address is one word cycle carrying data bits 15:0. To an odd address it is two byte cycles: data bits 7:0 at the address, then bits 15:8 at the address plus 1.
- R6: A 3-byte write to an even address is a word cycle with bits 15:0, then a byte cycle with bits 23:16 at the address plus 2. To an odd address it is a byte cycle with bits 7:0, then a word cycle with bits 23:8 at the address plus 1.
- R7: Every word cycle uses an even bus address. A write request never produces a read cycle.
- R8: While bus_valid is 1 and no done strobe has arrived, bus_addr, bus_wdata and bus_byte do not change.
- R9: A done strobe that arrives with bus_err=1 ends the request. No further bus cycle is issued, and the response has rsp_err=1.
- R10: A bus cycle that receives no done strobe is abandoned after exactly TMO_CYCLES clocks with bus_valid high. The response then has rsp_err=1 and no further cycle is issued.
- R11: rsp_valid is a one-clock pulse that follows the final bus cycle, and req_ready is 1 in the next clock. A req_valid that arrives while a request is in progress is ignored.
- R12: A request with length 0 is answered with rsp_err=1 and performs no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address of the fragment |
| req_len | input | 2 | Length in bytes (1 to 3; 0 is rejected) |
| req_wdata | input | 24 | Right-aligned write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Completion with bus error or timeout |
| rsp_rdata | output | 32 | Read result in longword position |
| bus_valid | output | 1 | Bus cycle in progress |
| bus_write | output | 1 | Cycle is a write |
| bus_byte | output | 1 | Write cycle is a single byte |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | 16 | Write data, byte placed in its lane |
| bus_rdata | input | 16 | Read word, valid with bus_done |
| bus_done | input | 1 | Current cycle finished |
| bus_err | input | 1 | Current cycle failed, valid with bus_done |

## Verification
Some properties are checked on every clock, whatever the traffic: word cycles land only on even addresses, the bus fields hold steady while a cycle waits, an error strobe produces an error response in the following clock with the bus released, a length-0 request is answered at once, and the response is a single-clock pulse. Other properties can only be shown by the bench scenarios. These are the exact number and order of cycles for each length, offset and direction, the placement of bytes in their lanes and of words in the read result, the skipped second cycle after an injected error, the length of a timed-out cycle, and a request pulsed while the sequencer is busy leaving no trace.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

    localparam int BUS_W  = 16;
    localparam int WDAT_W = 24;
    localparam int RDAT_W = 2 * BUS_W;
    localparam int LEN_W  = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CYC1 = 2'd1,
        ST_CYC2 = 2'd2,
        ST_DONE = 2'd3
    } state_e;

    // Which slice of the right-aligned write data a bus cycle carries.
    typedef enum logic [2:0] {
        DS_LO16  = 3'd0,
        DS_MID16 = 3'd1,
        DS_B0    = 3'd2,
        DS_B1    = 3'd3,
        DS_B2    = 3'd4
    } dsel_e;

    typedef struct packed {
        logic       byte_c;   // byte cycle (writes only)
        logic [1:0] aoff;     // offset added to the base address
        dsel_e      dsel;     // data slice
    } step_t;

    typedef struct packed {
        logic  two;           // a second bus cycle is needed
        logic  align;         // base address has bit 0 cleared (reads)
        step_t s1;
        step_t s2;
    } plan_t;

    function automatic step_t mk_step(input logic b, input logic [1:0] off, input dsel_e ds);
        step_t s;
        s.byte_c = b;
        s.aoff   = off;
        s.dsel   = ds;
        return s;
    endfunction

    // Build the minimal cycle plan for one fragment request.
    function automatic plan_t make_plan(input logic wr, input logic odd, input logic [LEN_W-1:0] len);
        plan_t p;
        p.two   = 1'b0;
        p.align = 1'b0;
        p.s1    = mk_step(1'b0, 2'd0, DS_LO16);
        p.s2    = mk_step(1'b0, 2'd2, DS_LO16);
        if (!wr) begin
            p.align = 1'b1;
            p.two   = ({1'b0, len} + {2'b00, odd}) > 3'd2;
        end else begin
            case (len)
                2'd1: p.s1 = mk_step(1'b1, 2'd0, DS_B0);
                2'd2: begin
                    if (odd) begin
                        p.two = 1'b1;
                        p.s1  = mk_step(1'b1, 2'd0, DS_B0);
                        p.s2  = mk_step(1'b1, 2'd1, DS_B1);
                    end
                end
                2'd3: begin
                    p.two = 1'b1;
                    if (odd) begin
                        p.s1 = mk_step(1'b1, 2'd0, DS_B0);
                        p.s2 = mk_step(1'b0, 2'd1, DS_MID16);
                    end else begin
                        p.s2 = mk_step(1'b1, 2'd2, DS_B2);
                    end
                end
                default: p.two = 1'b0;
            endcase
        end
        return p;
    endfunction

    function automatic logic [BUS_W-1:0] pick_data(input dsel_e ds, input logic [WDAT_W-1:0] w);
        case (ds)
            DS_LO16:  return w[15:0];
            DS_MID16: return w[23:8];
            DS_B0:    return {8'h00, w[7:0]};
            DS_B1:    return {8'h00, w[15:8]};
            DS_B2:    return {8'h00, w[23:16]};
            default:  return '0;
        endcase
    endfunction

    // A byte travels in the lane its address selects; the other lane is zero.
    function automatic logic [BUS_W-1:0] lane_place(input logic b, input logic a0, input logic [BUS_W-1:0] d);
        if (!b)  return d;
        if (a0)  return {d[7:0], 8'h00};
        return {8'h00, d[7:0]};
    endfunction

endpackage

// File: rtl/nbt_fsm.sv
module nbt_fsm
    import nbt_pkg::*;
#(
    parameter int TMO_CYCLES = 32
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   len_ok,
    input  logic   two,
    input  logic   bus_done,
    input  logic   bus_err,
    output state_e state,
    output logic   accept,
    output logic   bus_valid,
    output logic   rsp_valid,
    output logic   rsp_err,
    output logic   cap1,
    output logic   cap2
);
    localparam int CW = $clog2(TMO_CYCLES + 1);
    localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CYCLES - 1);

    state_e        nxt;
    logic          set_err;
    logic          err_q;
    logic [CW-1:0] wait_cnt;
    logic          tmo_hit;

    assign bus_valid = (state == ST_CYC1) || (state == ST_CYC2);
    assign tmo_hit   = bus_valid && (wait_cnt == TMO_LAST);
    assign cap1      = (state == ST_CYC1) && bus_done && !bus_err;
    assign cap2      = (state == ST_CYC2) && bus_done && !bus_err;
    assign rsp_valid = (state == ST_DONE);
    assign rsp_err   = (state == ST_DONE) && err_q;

    always_comb begin
        nxt     = state;
        accept  = 1'b0;
        set_err = 1'b0;
        case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (len_ok) begin
                        nxt    = ST_CYC1;
                        accept = 1'b1;
                    end else begin
                        nxt     = ST_DONE;
                        set_err = 1'b1;
                    end
                end
            end
            ST_CYC1: begin
                if (bus_done) begin
                    if (bus_err) begin
                        nxt     = ST_DONE;
                        set_err = 1'b1;
                    end else begin
                        nxt = two ? ST_CYC2 : ST_DONE;
                    end
                end else if (tmo_hit) begin
                    nxt     = ST_DONE;
                    set_err = 1'b1;
                end
            end
            ST_CYC2: begin
                if (bus_done) begin
                    nxt     = ST_DONE;
                    set_err = bus_err;
                end else if (tmo_hit) begin
                    nxt     = ST_DONE;
                    set_err = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            err_q    <= 1'b0;
            wait_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE) begin
                err_q <= set_err;
            end else if (set_err) begin
                err_q <= 1'b1;
            end
            if (nxt != state) begin
                wait_cnt <= '0;
            end else if (bus_valid) begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end

    // R9: an error strobe ends the request in the next clock
    assert_err_abort_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_done && bus_err) |=> (rsp_valid && rsp_err && !bus_valid));

    // R11: the response lasts a single clock
    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/nbt_step_drive.sv
module nbt_step_drive
    import nbt_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  state_e            state,
    input  plan_t             plan,
    input  logic              q_wr,
    input  logic [AW-1:0]     q_addr,
    input  logic [WDAT_W-1:0] q_wdata,
    input  logic              bus_valid,
    output logic              bus_write,
    output logic              bus_byte,
    output logic [AW-1:0]     bus_addr,
    output logic [BUS_W-1:0]  bus_wdata
);
    step_t         cur;
    logic [AW-1:0] base;

    always_comb begin
        cur       = (state == ST_CYC2) ? plan.s2 : plan.s1;
        base      = plan.align ? {q_addr[AW-1:1], 1'b0} : q_addr;
        bus_addr  = base + AW'(cur.aoff);
        bus_write = q_wr;
        bus_byte  = q_wr && cur.byte_c;
        bus_wdata = q_wr ? lane_place(cur.byte_c, bus_addr[0], pick_data(cur.dsel, q_wdata)) : '0;
    end

    // R7: a full-word cycle never targets an odd address
    assert_word_even_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_byte) |-> !bus_addr[0]);

    // R7: read cycles are always word cycles
    assert_read_word_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |-> !bus_byte);

endmodule

// File: rtl/nbt_rd_assemble.sv
module nbt_rd_assemble
    import nbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cap1,
    input  logic              cap2,
    input  logic              two,
    input  logic              hi_half,
    input  logic [BUS_W-1:0]  word_in,
    output logic [RDAT_W-1:0] result
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            result <= '0;
        end else if (cap1) begin
            if (two || !hi_half) begin
                result[BUS_W-1:0] <= word_in;
            end else begin
                result[RDAT_W-1:BUS_W] <= word_in;
            end
        end else if (cap2) begin
            result[RDAT_W-1:BUS_W] <= word_in;
        end
    end
endmodule

// File: rtl/nbt_seq.sv
module nbt_seq
    import nbt_pkg::*;
#(
    parameter int AW         = 24,
    parameter int TMO_CYCLES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [WDAT_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [RDAT_W-1:0] rsp_rdata,
    output logic              bus_valid,
    output logic              bus_write,
    output logic              bus_byte,
    output logic [AW-1:0]     bus_addr,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic [BUS_W-1:0]  bus_rdata,
    input  logic              bus_done,
    input  logic              bus_err
);
    state_e            state;
    logic              accept;
    logic              cap1, cap2;
    plan_t             plan_now, q_plan;
    logic              q_wr;
    logic [AW-1:0]     q_addr;
    logic [WDAT_W-1:0] q_wdata;

    assign plan_now  = make_plan(req_write, req_addr[0], req_len);
    assign req_ready = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_plan  <= '0;
            q_wr    <= 1'b0;
            q_addr  <= '0;
            q_wdata <= '0;
        end else if (accept) begin
            q_plan  <= plan_now;
            q_wr    <= req_write;
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
        end
    end

    nbt_fsm #(.TMO_CYCLES(TMO_CYCLES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .len_ok    (req_len != '0),
        .two       (q_plan.two),
        .bus_done  (bus_done),
        .bus_err   (bus_err),
        .state     (state),
        .accept    (accept),
        .bus_valid (bus_valid),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .cap1      (cap1),
        .cap2      (cap2)
    );

    nbt_step_drive #(.AW(AW)) u_drive (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .plan      (q_plan),
        .q_wr      (q_wr),
        .q_addr    (q_addr),
        .q_wdata   (q_wdata),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_byte  (bus_byte),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    nbt_rd_assemble u_rd (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .cap1    (cap1 && !q_wr),
        .cap2    (cap2 && !q_wr),
        .two     (q_plan.two),
        .hi_half (q_addr[1]),
        .word_in (bus_rdata),
        .result  (rsp_rdata)
    );

    // R8: a waiting cycle keeps its address, data and size
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_done) |=> (!bus_valid ||
            ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_byte))));

    // R11: the bus is quiet while responding, and idle follows the response
    assert_rsp_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !bus_valid);
    assert_ready_after_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> req_ready);

    // R12: length 0 is rejected in the next clock without a bus cycle
    assert_len_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid && (req_len == '0)) |=> (rsp_valid && rsp_err && !bus_valid));

endmodule

// File: tb/sim_nbt_seq.sv
module sim_nbt_seq;
    localparam int AW  = 24;
    localparam int TMO = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_len = '0;
    logic [23:0]   req_wdata = '0;
    logic          req_ready, rsp_valid, rsp_err;
    logic [31:0]   rsp_rdata;
    logic          bus_valid, bus_write, bus_byte;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_wdata;
    logic [15:0]   bus_rdata = '0;
    logic          bus_done = 1'b0, bus_err = 1'b0;

    always #5 clk = ~clk;

    nbt_seq #(.AW(AW), .TMO_CYCLES(TMO)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_done(bus_done), .bus_err(bus_err)
    );

    int n_chk = 0, n_err = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- bus model ----------------
    int            lg_n;
    logic          lg_w [4];
    logic          lg_b [4];
    logic [AW-1:0] lg_a [4];
    logic [15:0]   lg_d [4];
    bit            pend = 0, hang = 0, stab_bad = 0;
    int            lat = 0, hold_cnt = 0, err_at = -1, fix_lat = -1;

    function automatic logic [15:0] rmem(input logic [AW-1:0] a);
        return 16'hC3A5 ^ (a[15:0] * 16'd37);
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            bus_done = 0; bus_err = 0; pend = 0;
        end else if (bus_done) begin
            bus_done = 0; bus_err = 0; pend = 0;
        end else if (bus_valid) begin
            if (!pend) begin
                pend = 1;
                hold_cnt = 0;
                if (lg_n < 4) begin
                    lg_w[lg_n] = bus_write; lg_b[lg_n] = bus_byte;
                    lg_a[lg_n] = bus_addr;  lg_d[lg_n] = bus_wdata;
                end
                lg_n++;
                lat = (fix_lat >= 0) ? fix_lat : int'($urandom % 4);
            end else if (lg_n <= 4) begin
                if (lg_a[lg_n-1] != bus_addr || lg_d[lg_n-1] != bus_wdata || lg_b[lg_n-1] != bus_byte)
                    stab_bad = 1;
            end
            hold_cnt++;
            if (!hang) begin
                if (lat == 0) begin
                    bus_done  = 1;
                    bus_err   = (lg_n - 1 == err_at);
                    bus_rdata = rmem(bus_addr);
                end else begin
                    lat--;
                end
            end
        end else begin
            pend = 0;
        end
    end

    // ---------------- expected plan ----------------
    int            e_n;
    logic          e_b [2];
    logic [AW-1:0] e_a [2];
    logic [15:0]   e_d [2];

    function automatic logic [15:0] lane(input logic [AW-1:0] a, input logic [7:0] b);
        return a[0] ? {b, 8'h00} : {8'h00, b};
    endfunction

    task automatic plan_exp(input bit wr, input logic [AW-1:0] a, input logic [1:0] len, input logic [23:0] w);
        logic [AW-1:0] ae;
        ae = {a[AW-1:1], 1'b0};
        e_b[0] = 0; e_b[1] = 0; e_d[0] = '0; e_d[1] = '0;
        if (len == 0) begin
            e_n = 0;
        end else if (!wr) begin
            e_n = ((int'(len) + int'(a[0])) <= 2) ? 1 : 2;
            e_a[0] = ae; e_a[1] = ae + 2;
        end else if (len == 1) begin
            e_n = 1; e_b[0] = 1; e_a[0] = a; e_d[0] = lane(a, w[7:0]);
        end else if (len == 2 && !a[0]) begin
            e_n = 1; e_a[0] = a; e_d[0] = w[15:0];
        end else if (len == 2) begin
            e_n = 2;
            e_b[0] = 1; e_a[0] = a;     e_d[0] = lane(a, w[7:0]);
            e_b[1] = 1; e_a[1] = a + 1; e_d[1] = lane(a + 1, w[15:8]);
        end else if (!a[0]) begin
            e_n = 2;
            e_a[0] = a; e_d[0] = w[15:0];
            e_b[1] = 1; e_a[1] = a + 2; e_d[1] = lane(a + 2, w[23:16]);
        end else begin
            e_n = 2;
            e_b[0] = 1; e_a[0] = a; e_d[0] = lane(a, w[7:0]);
            e_a[1] = a + 1; e_d[1] = w[23:8];
        end
    endtask

    // ---------------- one request ----------------
    task automatic do_xact(input bit wr, input logic [AW-1:0] a, input logic [1:0] len,
                           input logic [23:0] w, input int inj_err, input bit inj_hang);
        string tg;
        int    n_exp;
        bit    e_err;
        logic [31:0] e_rd;
        plan_exp(wr, a, len, w);
        if (len == 0)      tg = "R12";
        else if (!wr)      tg = "R2/R3";
        else if (len == 1) tg = "R4";
        else if (len == 2) tg = "R5";
        else               tg = "R6";
        if (inj_hang)                   tg = "R10";
        else if (inj_err >= 0)          tg = "R9";
        n_exp = e_n; e_err = (len == 0);
        if (inj_hang && e_n > 0) begin n_exp = 1; e_err = 1; end
        else if (inj_err >= 0 && inj_err < e_n) begin n_exp = inj_err + 1; e_err = 1; end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        lg_n = 0; hang = inj_hang; err_at = inj_err;
        req_valid = 1; req_write = wr; req_addr = a; req_len = len; req_wdata = w;
        @(negedge clk);
        req_valid = 0;
        while (!rsp_valid) @(negedge clk);
        chk(rsp_err == e_err, {tg, " rsp_err"}, 32'(rsp_err), 32'(e_err));
        chk(lg_n == n_exp, {tg, " cycle count"}, 32'(lg_n), 32'(n_exp));
        for (int i = 0; i < n_exp && i < 2; i++) begin
            chk(lg_w[i] == wr, {tg, " cycle direction R7"}, 32'(lg_w[i]), 32'(wr));
            chk(lg_b[i] == e_b[i], {tg, " cycle size"}, 32'(lg_b[i]), 32'(e_b[i]));
            chk(lg_a[i] == e_a[i], {tg, " cycle address"}, 32'(lg_a[i]), 32'(e_a[i]));
            if (wr) chk(lg_d[i] == e_d[i], {tg, " cycle data"}, 32'(lg_d[i]), 32'(e_d[i]));
        end
        if (!wr && !e_err) begin
            if (e_n == 1) e_rd = a[1] ? {rmem(e_a[0]), 16'h0} : {16'h0, rmem(e_a[0])};
            else          e_rd = {rmem(e_a[1]), rmem(e_a[0])};
            chk(rsp_rdata == e_rd, "R3 read result", rsp_rdata, e_rd);
        end
        if (inj_hang) chk(hold_cnt == TMO, "R10 timeout length", 32'(hold_cnt), 32'(TMO));
        @(negedge clk);
        chk(!rsp_valid && req_ready && !bus_valid, "R11 pulse then idle",
            {29'd0, rsp_valid, req_ready, bus_valid}, 32'b010);
        hang = 0; err_at = -1;
    endtask

    initial begin
        #(10 * 150000);
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(req_ready && !bus_valid && !rsp_valid, "R1 reset state",
            {29'd0, req_ready, bus_valid, rsp_valid}, 32'b100);

        // every direction, offset and length
        for (int wr = 0; wr < 2; wr++)
            for (int off = 0; off < 4; off++)
                for (int ln = 1; ln < 4; ln++)
                    do_xact(wr[0], AW'(24'h001230 + off), ln[1:0], 24'hA1B2C3, -1, 0);

        // R12: length 0
        do_xact(0, 24'h000100, 2'd0, 24'h0, -1, 0);
        do_xact(1, 24'h000101, 2'd0, 24'h123456, -1, 0);

        // R9: errors on the first and second cycle
        do_xact(0, 24'h000041, 2'd3, 24'h0, 0, 0);
        do_xact(1, 24'h000043, 2'd2, 24'h00BEEF, 0, 0);
        do_xact(1, 24'h000045, 2'd3, 24'hCAFE12, 1, 0);

        // R10: no done strobe
        do_xact(0, 24'h000200, 2'd3, 24'h0, -1, 1);
        do_xact(1, 24'h000201, 2'd1, 24'h00005A, -1, 1);

        // R11: request pulsed while busy is ignored
        fix_lat = 3;
        @(negedge clk);
        lg_n = 0;
        req_valid = 1; req_write = 1; req_addr = 24'h000300; req_len = 2'd1; req_wdata = 24'h000077;
        @(negedge clk);
        req_addr = 24'h000555; req_len = 2'd3; req_write = 0;
        @(negedge clk);
        req_valid = 0;
        while (!rsp_valid) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(lg_n == 1, "R11 busy request ignored count", 32'(lg_n), 32'd1);
        chk(lg_a[0] == 24'h000300, "R11 busy request ignored address", 32'(lg_a[0]), 32'h300);
        fix_lat = -1;

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [1:0] ln;
            ln = 2'(1 + ($urandom % 3));
            do_xact(1'($urandom % 2), AW'($urandom), ln, 24'($urandom), -1, 0);
        end

        chk(!stab_bad, "R8 bus fields held while waiting", 32'(stab_bad), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule